// File: doc/BRIEF.md
# Time-Base, Watchdog and Tone Unit

This block turns a 32768 Hz clock enable into the slow timing services of a display controller. One shared divider supplies a selectable square-wave time base between 1 Hz and 128 Hz. The same divider drives a watchdog stage that raises a time-out flag after four periods of the selected rate. A separate small counter produces a complementary buzzer pair at 4 kHz or 2 kHz. An active-low, open-drain interrupt request is modelled as a drive enable plus the resolved line level. It can follow the time base, the watchdog flag, or both.

The block is controlled only through single-cycle command strobes, which come from an upstream command decoder. Each enable has its own on and off strobe, and where both arrive in the same cycle the off strobe wins. Further strobes clear the divider, clear the watchdog stage, select the tone, load the rate and halt or resume the whole timing chain. Every output is decoded from registers only, so no input reaches an output in the same cycle.

Top module: `chrono_tone_unit`

## Requirements
- R1: After reset, tb_clk, wd_flag, irq_drive, buz_p and buz_n are all 0, irq_line is 1, the system is running and the rate code is 7 (128 Hz).
- R2: The divider advances by one only in cycles where tick_en is 1 and the system is running. With tick_en at 0, tb_clk does not change.
- R3: Rate code s (loaded from rate_code on cmd_rate_ld; 0 means 1 Hz and 7 means 128 Hz) makes tb_clk a square wave with a period of 2^(15-s) ticks and 50% duty. tb_clk is low for the first half-period after a divider clear.
- R4: cmd_tb_clr zeroes the divider, so tb_clk is 0 in the cycle after the strobe.
- R5: With the watchdog enabled and both stages cleared together, wd_flag rises exactly 4·2^(15-s) ticks after the clear and not one tick earlier.
- R6: Once set, wd_flag stays 1 until cmd_wd_clr or cmd_irq_off. cmd_wd_clr clears the flag and restarts the four-period count.
- R7: irq_drive = irq_en AND ((timer_en AND NOT tb_clk) OR (wd_en AND wd_flag)). The three enables are independent, and irq_line is always NOT irq_drive.
- R8: cmd_irq_off releases irq_drive in the next cycle and clears wd_flag. A later cmd_irq_on therefore does not reassert the line from an old time-out.
- R9: cmd_tone_hi starts a 4 kHz tone of 8 ticks per period. buz_p is 0 for ticks 0 to 3 and 1 for ticks 4 to 7 after the strobe, buz_n is its complement, and the two are never both 1.
- R10: cmd_tone_lo starts a 2 kHz tone of 16 ticks per period. buz_p is 1 from tick 8 to tick 15 after the strobe, and buz_n is its complement.
- R11: cmd_tone_off holds both buzzer outputs at 0 from the next cycle on. It wins over a tone start in the same cycle.
- R12: cmd_sys_off freezes the divider, watchdog and tone counters and forces both buzzer outputs to 0. cmd_sys_on resumes counting from the frozen value. Off wins over on.
- R13: While the watchdog is disabled its stage does not count and wd_flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 32768 Hz enable, one cycle per tick |
| cmd_sys_off | input | 1 | Halt the timing chain and silence the buzzer |
| cmd_sys_on | input | 1 | Resume the timing chain |
| cmd_tb_on | input | 1 | Route the time base to the interrupt |
| cmd_tb_off | input | 1 | Stop routing the time base |
| cmd_tb_clr | input | 1 | Zero the shared divider |
| cmd_wd_on | input | 1 | Enable the watchdog stage and its flag |
| cmd_wd_off | input | 1 | Disable the watchdog stage |
| cmd_wd_clr | input | 1 | Clear the watchdog count and flag |
| cmd_irq_on | input | 1 | Enable the interrupt output |
| cmd_irq_off | input | 1 | Disable the interrupt output and clear the flag |
| cmd_tone_off | input | 1 | Stop the buzzer |
| cmd_tone_hi | input | 1 | Start the 4 kHz tone |
| cmd_tone_lo | input | 1 | Start the 2 kHz tone |
| cmd_rate_ld | input | 1 | Load rate_code as the time-base rate |
| rate_code | input | 3 | Rate code, 0 = 1 Hz to 7 = 128 Hz |
| tb_clk | output | 1 | Selected time-base square wave |
| wd_flag | output | 1 | Watchdog time-out flag |
| buz_p | output | 1 | Buzzer output, true phase |
| buz_n | output | 1 | Buzzer output, inverted phase |
| irq_drive | output | 1 | 1 when the open-drain request pulls low |
| irq_line | output | 1 | Resolved request line level with pull-up |

## Verification
The hardest state to reach is an exact watchdog time-out. The stage counts period boundaries of a divider that runs freely, so an arbitrary clear lands somewhere inside a period. The stimulus therefore issues the divider clear and the watchdog clear in the same cycle, which makes the time-out tick known, and it checks both the tick before the time-out and the time-out tick itself. It does this at two rates. The flag is then held across a later period boundary and released by each of its two clearing strobes in turn.

// File: rtl/chrono_pkg.sv
package chrono_pkg;
    localparam int RATE_W = 3;
    localparam logic [RATE_W-1:0] RATE_RESET = '1;

    typedef struct packed {
        logic              running;
        logic              tb_en;
        logic              wd_en;
        logic              irq_en;
        logic [RATE_W-1:0] rate;
    } ctrl_t;
endpackage

// File: rtl/chrono_divider.sv
module chrono_divider #(
    parameter int DIV_W  = 15,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              tb_clk,
    output logic              period_end
);
    localparam logic [DIV_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DIV_W-1:0] mask;
    logic [DIV_W-1:0] aligned;

    always_comb begin
        s_d     = s_q;
        mask    = ALL_ONES >> rate;
        aligned = s_q.div << rate;
        if (clr)
            s_d.div = '0;
        else if (step)
            s_d.div = s_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // rate s taps bit DIV_W-1-s; a period closes when all bits below and at the tap are set
    assign tb_clk     = aligned[DIV_W-1];
    assign period_end = step & ~clr & ((s_q.div & mask) == mask);

    assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(s_q.div));
    assert_clr_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tb_clk);
endmodule

// File: rtl/chrono_watchdog.sv
module chrono_watchdog #(
    parameter int PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic period_end,
    input  logic clr,
    input  logic release_flag,
    output logic flag
);
    localparam int CNT_W = (PERIODS > 2) ? $clog2(PERIODS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIODS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } wd_state_t;

    wd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt  = '0;
            s_d.flag = 1'b0;
        end else begin
            if (enable && period_end) begin
                if (s_q.cnt == LAST) begin
                    s_d.cnt  = '0;
                    s_d.flag = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            if (release_flag)
                s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.flag;

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !release_flag) |=> flag);
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || release_flag) |=> !flag);
    assert_idle_count_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clr) |=> $stable(s_q.cnt));
endmodule

// File: rtl/chrono_tone.sv
module chrono_tone #(
    parameter int TONE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic running,
    input  logic cmd_off,
    input  logic cmd_hi,
    input  logic cmd_lo,
    output logic buz_p,
    output logic buz_n
);
    localparam int HI_TAP = TONE_W - 2;
    localparam int LO_TAP = TONE_W - 1;

    typedef struct packed {
        logic              on;
        logic              hi;
        logic [TONE_W-1:0] cnt;
    } tone_state_t;

    tone_state_t s_d, s_q;
    logic tap;
    logic live;

    always_comb begin
        s_d = s_q;
        if (cmd_off) begin
            s_d.on = 1'b0;
        end else if (cmd_hi || cmd_lo) begin
            s_d.on  = 1'b1;
            s_d.hi  = cmd_hi;
            s_d.cnt = '0;
        end else if (step) begin
            s_d.cnt = s_q.cnt + TONE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tap   = s_q.hi ? s_q.cnt[HI_TAP] : s_q.cnt[LO_TAP];
    assign live  = s_q.on & running;
    assign buz_p = live & tap;
    assign buz_n = live & ~tap;

    assert_pair_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(buz_p && buz_n));
    assert_tone_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> (!buz_p && !buz_n));
endmodule

// File: rtl/chrono_tone_unit.sv
module chrono_tone_unit
    import chrono_pkg::*;
#(
    parameter int PRE_W   = 8,
    parameter int PERIODS = 4,
    parameter int TONE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cmd_sys_off,
    input  logic              cmd_sys_on,
    input  logic              cmd_tb_on,
    input  logic              cmd_tb_off,
    input  logic              cmd_tb_clr,
    input  logic              cmd_wd_on,
    input  logic              cmd_wd_off,
    input  logic              cmd_wd_clr,
    input  logic              cmd_irq_on,
    input  logic              cmd_irq_off,
    input  logic              cmd_tone_off,
    input  logic              cmd_tone_hi,
    input  logic              cmd_tone_lo,
    input  logic              cmd_rate_ld,
    input  logic [RATE_W-1:0] rate_code,
    output logic              tb_clk,
    output logic              wd_flag,
    output logic              buz_p,
    output logic              buz_n,
    output logic              irq_drive,
    output logic              irq_line
);
    localparam int N_RATES = 1 << RATE_W;
    localparam int DIV_W   = PRE_W + N_RATES - 1;

    ctrl_t c_d, c_q;
    logic  step;
    logic  period_end;

    always_comb begin
        c_d = c_q;
        if (cmd_sys_on)  c_d.running = 1'b1;
        if (cmd_sys_off) c_d.running = 1'b0;
        if (cmd_tb_on)   c_d.tb_en   = 1'b1;
        if (cmd_tb_off)  c_d.tb_en   = 1'b0;
        if (cmd_wd_on)   c_d.wd_en   = 1'b1;
        if (cmd_wd_off)  c_d.wd_en   = 1'b0;
        if (cmd_irq_on)  c_d.irq_en  = 1'b1;
        if (cmd_irq_off) c_d.irq_en  = 1'b0;
        if (cmd_rate_ld) c_d.rate    = rate_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.running <= 1'b1;
            c_q.rate    <= RATE_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign step = tick_en & c_q.running;

    chrono_divider #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .clr        (cmd_tb_clr),
        .rate       (c_q.rate),
        .tb_clk     (tb_clk),
        .period_end (period_end)
    );

    chrono_watchdog #(.PERIODS(PERIODS)) u_wd (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (c_q.wd_en),
        .period_end   (period_end),
        .clr          (cmd_wd_clr),
        .release_flag (cmd_irq_off),
        .flag         (wd_flag)
    );

    chrono_tone #(.TONE_W(TONE_W)) u_tone (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .running (c_q.running),
        .cmd_off (cmd_tone_off),
        .cmd_hi  (cmd_tone_hi),
        .cmd_lo  (cmd_tone_lo),
        .buz_p   (buz_p),
        .buz_n   (buz_n)
    );

    assign irq_drive = c_q.irq_en & ((c_q.tb_en & ~tb_clk) | (c_q.wd_en & wd_flag));
    assign irq_line  = ~irq_drive;

    assert_irq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq_off |=> !irq_drive);
    assert_sys_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sys_off |=> (!buz_p && !buz_n));
    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_irq_off && !cmd_irq_on) |=> !irq_drive until_with cmd_irq_on);
endmodule

// File: tb/sim_chrono_tone_unit.sv
module sim_chrono_tone_unit;
    localparam int NC = 14;
    localparam logic [NC-1:0] M_SYS_OFF  = 14'd1 << 0;
    localparam logic [NC-1:0] M_SYS_ON   = 14'd1 << 1;
    localparam logic [NC-1:0] M_TB_ON    = 14'd1 << 2;
    localparam logic [NC-1:0] M_TB_OFF   = 14'd1 << 3;
    localparam logic [NC-1:0] M_TB_CLR   = 14'd1 << 4;
    localparam logic [NC-1:0] M_WD_ON    = 14'd1 << 5;
    localparam logic [NC-1:0] M_WD_OFF   = 14'd1 << 6;
    localparam logic [NC-1:0] M_WD_CLR   = 14'd1 << 7;
    localparam logic [NC-1:0] M_IRQ_ON   = 14'd1 << 8;
    localparam logic [NC-1:0] M_IRQ_OFF  = 14'd1 << 9;
    localparam logic [NC-1:0] M_TONE_OFF = 14'd1 << 10;
    localparam logic [NC-1:0] M_TONE_HI  = 14'd1 << 11;
    localparam logic [NC-1:0] M_TONE_LO  = 14'd1 << 12;
    localparam logic [NC-1:0] M_RATE_LD  = 14'd1 << 13;

    localparam int S_TB = 0, S_FLAG = 1, S_IRQ = 2, S_BP = 3, S_BN = 4, S_LINE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [NC-1:0] cmd = '0;
    logic [2:0] rsel = 3'd7;
    logic tb_clk, wd_flag, buz_p, buz_n, irq_drive, irq_line;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } exp_t;
    exp_t q[$];
    exp_t cur;
    logic got;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chrono_tone_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick),
        .cmd_sys_off(cmd[0]), .cmd_sys_on(cmd[1]),
        .cmd_tb_on(cmd[2]), .cmd_tb_off(cmd[3]), .cmd_tb_clr(cmd[4]),
        .cmd_wd_on(cmd[5]), .cmd_wd_off(cmd[6]), .cmd_wd_clr(cmd[7]),
        .cmd_irq_on(cmd[8]), .cmd_irq_off(cmd[9]),
        .cmd_tone_off(cmd[10]), .cmd_tone_hi(cmd[11]), .cmd_tone_lo(cmd[12]),
        .cmd_rate_ld(cmd[13]), .rate_code(rsel),
        .tb_clk(tb_clk), .wd_flag(wd_flag), .buz_p(buz_p), .buz_n(buz_n),
        .irq_drive(irq_drive), .irq_line(irq_line)
    );

    function automatic logic sample(input int s);
        case (s)
            S_TB:    return tb_clk;
            S_FLAG:  return wd_flag;
            S_IRQ:   return irq_drive;
            S_BP:    return buz_p;
            S_BN:    return buz_n;
            default: return irq_line;
        endcase
    endfunction

    // monitor: compare queued expectations in the cycle they fall due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            cur = q.pop_front();
            got = sample(cur.sig);
            n_chk++;
            if (cur.at != cyc || got !== cur.val) begin
                n_fail++;
                $display("FAIL %s sig%0d cycle %0d: actual %b expected %b (due %0d)",
                         cur.req, cur.sig, cyc, got, cur.val, cur.at);
            end
        end
    end

    task automatic expect_at(input int at, input int sig, input logic val, input string req);
        exp_t e;
        e.at = at; e.sig = sig; e.val = val; e.req = req;
        q.push_back(e);
    endtask

    task automatic pulse(input logic [NC-1:0] m, output int eff);
        @(negedge clk);
        cmd = m;
        eff = cyc + 1;
        @(negedge clk);
        cmd = '0;
    endtask

    task automatic drain;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int e;
        int x;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(cyc + 1, S_TB,   1'b0, "R1");
        expect_at(cyc + 1, S_FLAG, 1'b0, "R1");
        expect_at(cyc + 1, S_IRQ,  1'b0, "R1");
        expect_at(cyc + 1, S_BP,   1'b0, "R1");
        expect_at(cyc + 1, S_BN,   1'b0, "R1");
        expect_at(cyc + 1, S_LINE, 1'b1, "R1");
        drain();

        // R2 no tick, no movement; R1 default rate is 128 Hz
        pulse(M_TB_CLR, e);
        expect_at(e + 150, S_TB, 1'b0, "R2");
        drain();
        tick = 1'b1;
        x = cyc;
        expect_at(x + 127, S_TB, 1'b0, "R1");
        expect_at(x + 128, S_TB, 1'b1, "R1");
        drain();

        // R3 rate 4 (16 Hz) and rate 0 (1 Hz)
        rsel = 3'd4;
        pulse(M_RATE_LD | M_TB_CLR, e);
        expect_at(e + 1023, S_TB, 1'b0, "R3");
        expect_at(e + 1024, S_TB, 1'b1, "R3");
        expect_at(e + 2047, S_TB, 1'b1, "R3");
        expect_at(e + 2048, S_TB, 1'b0, "R3");
        drain();
        rsel = 3'd0;
        pulse(M_RATE_LD | M_TB_CLR, e);
        expect_at(e + 1, S_TB, 1'b0, "R4");
        expect_at(e + 16383, S_TB, 1'b0, "R3");
        expect_at(e + 16384, S_TB, 1'b1, "R3");
        drain();

        // R7 timer enabled alone does not drive; then time base on the request
        rsel = 3'd7;
        pulse(M_RATE_LD | M_TB_ON | M_TB_CLR, e);
        expect_at(e + 20, S_IRQ, 1'b0, "R7");
        drain();
        pulse(M_IRQ_ON | M_TB_CLR, e);
        expect_at(e + 1,   S_IRQ,  1'b1, "R7");
        expect_at(e + 127, S_IRQ,  1'b1, "R3");
        expect_at(e + 128, S_IRQ,  1'b0, "R3");
        expect_at(e + 128, S_LINE, 1'b1, "R7");
        expect_at(e + 256, S_IRQ,  1'b1, "R3");
        drain();

        // R5 watchdog time-out at 128 Hz, R6 hold and clear
        pulse(M_TB_OFF | M_WD_ON | M_TB_CLR | M_WD_CLR, e);
        expect_at(e + 1023, S_FLAG, 1'b0, "R5");
        expect_at(e + 1023, S_IRQ,  1'b0, "R5");
        expect_at(e + 1024, S_FLAG, 1'b1, "R5");
        expect_at(e + 1024, S_IRQ,  1'b1, "R7");
        expect_at(e + 1024, S_LINE, 1'b0, "R7");
        expect_at(e + 1500, S_FLAG, 1'b1, "R6");
        expect_at(e + 1500, S_IRQ,  1'b1, "R6");
        drain();
        pulse(M_WD_CLR, e);
        expect_at(e + 1, S_FLAG, 1'b0, "R6");
        expect_at(e + 1, S_IRQ,  1'b0, "R6");
        drain();

        // R8 disabling the request clears the flag
        pulse(M_TB_CLR | M_WD_CLR, e);
        expect_at(e + 1024, S_FLAG, 1'b1, "R8");
        drain();
        pulse(M_IRQ_OFF, e);
        expect_at(e + 1, S_IRQ,  1'b0, "R8");
        expect_at(e + 1, S_FLAG, 1'b0, "R8");
        drain();
        pulse(M_IRQ_ON, e);
        expect_at(e + 1, S_IRQ, 1'b0, "R8");
        drain();

        // R13 disabled watchdog never sets; R5 at 64 Hz with request disabled (R7)
        pulse(M_WD_OFF | M_IRQ_OFF | M_TB_CLR | M_WD_CLR, e);
        expect_at(e + 2000, S_FLAG, 1'b0, "R13");
        drain();
        rsel = 3'd6;
        pulse(M_RATE_LD | M_WD_ON | M_TB_CLR | M_WD_CLR, e);
        expect_at(e + 2047, S_FLAG, 1'b0, "R5");
        expect_at(e + 2048, S_FLAG, 1'b1, "R5");
        expect_at(e + 2048, S_IRQ,  1'b0, "R7");
        drain();
        pulse(M_WD_OFF | M_WD_CLR, e);

        // R9 4 kHz tone
        pulse(M_TONE_HI, e);
        expect_at(e + 3, S_BP, 1'b0, "R9");
        expect_at(e + 4, S_BP, 1'b1, "R9");
        expect_at(e + 4, S_BN, 1'b0, "R9");
        expect_at(e + 7, S_BP, 1'b1, "R9");
        expect_at(e + 8, S_BP, 1'b0, "R9");
        expect_at(e + 8, S_BN, 1'b1, "R9");
        drain();
        // R10 2 kHz tone
        pulse(M_TONE_LO, e);
        expect_at(e + 7,  S_BP, 1'b0, "R10");
        expect_at(e + 8,  S_BP, 1'b1, "R10");
        expect_at(e + 8,  S_BN, 1'b0, "R10");
        expect_at(e + 15, S_BP, 1'b1, "R10");
        expect_at(e + 16, S_BP, 1'b0, "R10");
        expect_at(e + 16, S_BN, 1'b1, "R10");
        drain();

        // R12 system halt freezes and silences, resume counts on
        rsel = 3'd7;
        pulse(M_SYS_OFF | M_TB_CLR | M_RATE_LD, e);
        expect_at(e + 1,   S_BP, 1'b0, "R12");
        expect_at(e + 1,   S_BN, 1'b0, "R12");
        expect_at(e + 500, S_TB, 1'b0, "R12");
        expect_at(e + 500, S_BP, 1'b0, "R12");
        expect_at(e + 500, S_BN, 1'b0, "R12");
        drain();
        pulse(M_SYS_ON, e);
        expect_at(e + 127, S_TB, 1'b0, "R12");
        expect_at(e + 128, S_TB, 1'b1, "R12");
        drain();

        // R11 tone off
        pulse(M_TONE_OFF, e);
        expect_at(e + 1, S_BP, 1'b0, "R11");
        expect_at(e + 1, S_BN, 1'b0, "R11");
        expect_at(e + 9, S_BP, 1'b0, "R11");
        expect_at(e + 9, S_BN, 1'b0, "R11");
        drain();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule